// File: doc/BRIEF.md
# Serial Bus Pause Controller

This block sits between the pins of a serial flash device and its command shifter. It runs on the device's internal clock and samples chip select, the serial clock, serial data in and an active-low pause input through a synchronizer of configurable depth. While chip select is low, it turns every rising serial clock edge into a one-cycle shift strobe and captures the data-in bit with it. On every falling edge it latches the shifter's next output bit for the data-out pin.

The pause input freezes the bus without ending the transaction. The pause state can change only while the serial clock is low. A request made while the clock is high waits until the clock next falls. During a pause the shift strobe is suppressed and the data-out enable is dropped. Clock and data-in activity is ignored, and the latched output bit is kept so that the pin drives the same value again on resume.

If chip select rises during a pause, the interface reset is raised and the bus is locked. Bus activity restarts only after the pause input is high while chip select is high, followed by a new chip select assertion. A busy flag from the internal write engine passes straight through and is not affected by the pause.

Top module: `bus_pause_ctrl`

## Requirements
- R1: After reset, with chip select high, shift_en is 0, so_oe is 0 and ifc_rst is 1.
- R2: With chip select low and no pause, each serial clock rising edge gives exactly one shift_en pulse, and rx_bit holds the SI level sampled at that edge. Each falling edge loads tx_bit into so_o. so_oe is high exactly when tx_drive is high.
- R3: When hold_n goes low while sclk is low and chip select is low, the block enters the pause. so_oe goes low, and sclk toggles then produce no shift_en pulse.
- R4: When hold_n falls while sclk is high, the pause does not start yet and so_oe stays high. It starts once sclk goes low.
- R5: When hold_n rises while sclk is high during a pause, the pause continues and so_oe stays low. It ends once sclk goes low.
- R6: When the pause ends, so_o shows the bit it held before the pause, even if tx_bit changed during the pause.
- R7: ifc_rst is 1 whenever chip select is high, including when chip select rises during a pause.
- R8: After chip select rises during a pause, and as long as hold_n stays low, a new chip select assertion gives no shift_en and no so_oe. Normal shifting returns after hold_n is high with chip select high, followed by chip select low.
- R9: busy_o equals busy_i at all times, pause or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select pin, active low |
| sclk | input | 1 | Serial clock pin |
| si | input | 1 | Serial data-in pin |
| hold_n | input | 1 | Pause pin, active low |
| tx_bit | input | 1 | Next output bit from the shifter |
| tx_drive | input | 1 | Shifter requests the output driver |
| busy_i | input | 1 | Write engine busy flag |
| so_o | output | 1 | Data-out value |
| so_oe | output | 1 | Data-out driver enable |
| shift_en | output | 1 | One-cycle shift strobe |
| rx_bit | output | 1 | Data-in bit captured with shift_en |
| ifc_rst | output | 1 | Interface reset to the shifter |
| busy_o | output | 1 | Busy flag passed through |

## Verification
The assertions assume that the pins change far more slowly than the internal clock. They also assume that the serial clock stays at each level for several synchronizer delays, so that every edge is seen as one clean transition. The stimulus changes one pin at a time and then waits eight internal cycles before the next change, which is longer than the synchronizer depth plus the edge register. The pause input and chip select never move in the same step as the serial clock, so every deferred case has a clear order of events.

// File: rtl/bus_pause_pkg.sv
package bus_pause_pkg;
   localparam int MAX_SYNC = 4;

   typedef struct packed {
      logic cs_n;
      logic sclk;
      logic si;
      logic hold_n;
   } pins_t;

   localparam int PIN_W = $bits(pins_t);
   localparam pins_t PINS_IDLE = '{cs_n: 1'b1, sclk: 1'b0, si: 1'b0, hold_n: 1'b1};
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
   parameter int            W       = 4,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial begin
      if (STAGES < 0 || STAGES > bus_pause_pkg::MAX_SYNC)
         $error("pin_sync: STAGES out of range");
   end

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/pause_fsm.sv
module pause_fsm (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_s,
   input  logic sclk_s,
   input  logic hold_s,
   output logic paused,
   output logic locked,
   output logic active,
   output logic ifc_rst
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         paused  <= 1'b0;
         locked  <= 1'b0;
         ifc_rst <= 1'b1;
      end else begin
         ifc_rst <= cs_s;
         if (cs_s) begin
            paused <= 1'b0;
            locked <= hold_s ? 1'b0 : (locked | paused);
         end else if (!sclk_s && !locked) begin
            paused <= !hold_s;
         end
      end
   end

   assign active = !cs_s && !paused && !locked;

   // R3
   pause_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(paused) |-> $past(!sclk_s && !cs_s));
   // R5
   pause_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(paused) && !$past(cs_s)) |-> $past(!sclk_s && hold_s));
   // R7
   deselect_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> ifc_rst);
   // R8
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !cs_s) |=> locked);
endmodule

// File: rtl/shift_path.sv
module shift_path (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_s,
   input  logic si_s,
   input  logic active,
   input  logic paused,
   input  logic tx_bit,
   input  logic tx_drive,
   output logic shift_en,
   output logic rx_bit,
   output logic so_o,
   output logic so_oe
);
   logic sclk_d;
   logic rise, fall;

   assign rise = sclk_s && !sclk_d;
   assign fall = !sclk_s && sclk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d   <= 1'b0;
         shift_en <= 1'b0;
         rx_bit   <= 1'b0;
         so_o     <= 1'b0;
      end else begin
         sclk_d   <= sclk_s;
         shift_en <= rise && active;
         if (rise && active) rx_bit <= si_s;
         if (fall && active) so_o <= tx_bit;
      end
   end

   assign so_oe = active && tx_drive;

   // R3
   no_strobe_in_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      paused |=> !shift_en);
   // R3
   no_drive_in_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      paused |-> !so_oe);
   // R6
   so_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (paused && $past(paused)) |-> $stable(so_o));
endmodule

// File: rtl/bus_pause_ctrl.sv
module bus_pause_ctrl #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sclk,
   input  logic si,
   input  logic hold_n,
   input  logic tx_bit,
   input  logic tx_drive,
   input  logic busy_i,
   output logic so_o,
   output logic so_oe,
   output logic shift_en,
   output logic rx_bit,
   output logic ifc_rst,
   output logic busy_o
);
   import bus_pause_pkg::*;

   pins_t raw_pins, s_pins;
   logic  paused, locked, active;

   assign raw_pins = '{cs_n: cs_n, sclk: sclk, si: si, hold_n: hold_n};

   pin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_pins), .q(s_pins)
   );

   pause_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .cs_s(s_pins.cs_n), .sclk_s(s_pins.sclk),
      .hold_s(s_pins.hold_n), .paused(paused), .locked(locked),
      .active(active), .ifc_rst(ifc_rst)
   );

   shift_path u_path (
      .clk(clk), .rst_n(rst_n), .sclk_s(s_pins.sclk), .si_s(s_pins.si),
      .active(active), .paused(paused), .tx_bit(tx_bit), .tx_drive(tx_drive),
      .shift_en(shift_en), .rx_bit(rx_bit), .so_o(so_o), .so_oe(so_oe)
   );

   assign busy_o = busy_i;

   // R8
   locked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> !shift_en);
   // R9
   busy_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (paused && busy_i) |-> busy_o);
endmodule

// File: tb/tb_bus_pause_ctrl.sv
module tb_bus_pause_ctrl;
   logic clk = 1'b0, rst_n = 1'b0;
   logic cs_n = 1'b1, sclk = 1'b0, si = 1'b0, hold_n = 1'b1;
   logic tx_bit = 1'b0, tx_drive = 1'b0, busy_i = 1'b0;
   logic so_o, so_oe, shift_en, rx_bit, ifc_rst, busy_o;
   int   checks = 0, errors = 0, strobes = 0;
   logic [31:0] rxv = '0;

   always #2.5 clk = ~clk;

   bus_pause_ctrl dut (.*);

   always @(negedge clk) if (shift_en) begin
      strobes++;
      rxv = {rxv[30:0], rx_bit};
   end

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic settle(); repeat (8) @(negedge clk); endtask
   task automatic pulse(input logic d);
      si = d; settle(); sclk = 1'b1; settle(); sclk = 1'b0; settle();
   endtask

   task automatic t_reset();
      chk(shift_en == 0 && so_oe == 0, "R1 idle outputs", {shift_en, so_oe}, 0);
      chk(ifc_rst == 1, "R1 ifc_rst", ifc_rst, 1);
   endtask

   task automatic t_shift();
      logic [7:0] pat = 8'hA6;
      cs_n = 0; tx_drive = 1; settle();
      chk(ifc_rst == 0, "R7 released", ifc_rst, 0);
      chk(so_oe == 1, "R2 drive", so_oe, 1);
      strobes = 0;
      for (int i = 7; i >= 0; i--) pulse(pat[i]);
      chk(strobes == 8, "R2 strobe count", strobes, 8);
      chk(rxv[7:0] == pat, "R2 rx bits", rxv[7:0], pat);
      tx_bit = 1; pulse(0);
      chk(so_o == 1, "R2 so follows tx", so_o, 1);
      tx_bit = 0; pulse(0);
      chk(so_o == 0, "R2 so follows tx low", so_o, 0);
   endtask

   task automatic t_pause_low();
      strobes = 0;
      pulse(1); pulse(0);
      hold_n = 0; settle();
      chk(so_oe == 0, "R3 so_oe off", so_oe, 0);
      for (int i = 0; i < 4; i++) pulse(1);
      chk(strobes == 2, "R3 no strobes", strobes, 2);
      hold_n = 1; settle();
      chk(so_oe == 1, "R3 resumed", so_oe, 1);
      pulse(1);
      chk(strobes == 3, "R3 strobes resume", strobes, 3);
   endtask

   task automatic t_deferred();
      sclk = 1; settle();
      hold_n = 0; settle();
      chk(so_oe == 1, "R4 entry deferred", so_oe, 1);
      sclk = 0; settle();
      chk(so_oe == 0, "R4 entry on low", so_oe, 0);
      sclk = 1; settle();
      hold_n = 1; settle();
      chk(so_oe == 0, "R5 exit deferred", so_oe, 0);
      sclk = 0; settle();
      chk(so_oe == 1, "R5 exit on low", so_oe, 1);
   endtask

   task automatic t_resume_bit();
      tx_bit = 1; pulse(0);
      chk(so_o == 1, "R6 pre pause", so_o, 1);
      hold_n = 0; settle();
      tx_bit = 0; pulse(1); pulse(0);
      hold_n = 1; settle();
      chk(so_oe == 1 && so_o == 1, "R6 same bit", so_o, 1);
      pulse(0);
      chk(so_o == 0, "R6 new bit after", so_o, 0);
   endtask

   task automatic t_lock();
      hold_n = 0; busy_i = 1; settle();
      chk(busy_o == 1, "R9 busy in pause", busy_o, 1);
      cs_n = 1; settle();
      chk(ifc_rst == 1, "R7 reset in pause", ifc_rst, 1);
      cs_n = 0; settle();
      strobes = 0;
      pulse(1); pulse(1);
      chk(strobes == 0 && so_oe == 0, "R8 locked", strobes, 0);
      hold_n = 1; settle();
      pulse(1);
      chk(strobes == 0, "R8 still locked", strobes, 0);
      busy_i = 0; settle();
      chk(busy_o == 0, "R9 busy low", busy_o, 0);
      cs_n = 1; settle(); cs_n = 0; settle();
      pulse(1);
      chk(strobes == 1 && so_oe == 1, "R8 unlocked", strobes, 1);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1; settle();
      t_reset();
      t_shift();
      t_pause_low();
      t_deferred();
      t_resume_bit();
      t_lock();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule